// File: doc/BRIEF.md
# Floppy Controller Multi-Sector Read Emulator

This block models the register view of a floppy disk controller as a host CPU sees it on a byte-wide bus. The host writes command codes into a command register and polls a status register. The block also has track, sector and data registers and a drive-select latch. Two commands are recognised. The first is a restore, which homes the head to track zero. The second is a multi-sector read, which streams every remaining sector of the current track to the host.

No disk mechanics are modelled. The bytes come from a backing-store port. For each byte, the block sends a one-cycle request that carries drive, track, sector and byte index, and it takes the returned byte one cycle later. The host handshake works as follows. When the status shows a byte ready, the host reads the data register, and that read starts the fetch of the next byte. Busy stays set until the last byte of the last sector on the track has been taken. A host boot loop therefore polls status, stores each byte as it becomes ready, and treats busy falling as the end of the transfer.

Top module: `fdc_mread`

## Requirements
- R1: After reset, status, track, sector and drive-select all read 0, and no store request is issued.
- R2: Status reads as {6'b0, ready, busy}: bit 0 is busy and bit 1 is byte-ready. Byte-ready is never set without busy, and status reads 0 while idle.
- R3: Command 8'h0B (restore) sets track to 0 and holds busy for exactly RESTORE_CYCLES cycles.
- R4: Command 8'h9C (multi-sector read) delivers sectors in ascending order from the sector register value up to TRACK_SECTORS. It delivers bytes in index order 0 to SECTOR_BYTES-1, and each byte is the store's value for the current drive, track, sector and index. The sector register shows the sector being transferred.
- R5: A multi-sector read started with sector register 0 begins at sector 1.
- R6: A host read of the data register while a byte is ready clears byte-ready. The store request follows in the next cycle. Byte-ready is visible again to the third status poll after the read, which is three cycles later. The first byte after the command follows the same timing.
- R7: Once the last byte of sector TRACK_SECTORS has been read, busy drops to 0 with byte-ready 0, and the sector register holds TRACK_SECTORS.
- R8: While busy, writes to the command, track, sector and drive-select registers are ignored.
- R9: Register addresses are 0 for command (write) and status (read), 1 for track, 2 for sector, 3 for data and 4 for drive-select. Track, sector and drive-select written while idle read back unchanged.
- R10: Command codes other than 8'h0B and 8'h9C have no effect.
- R11: Store requests occur only while busy, each lasts one cycle, and there is exactly one request per delivered byte.
- R12: A drive-select write with a value of DRIVES or above is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational on address |
| store_req | output | 1 | Backing-store byte request |
| store_drive | output | DRV_W | Requested drive |
| store_track | output | 8 | Requested track |
| store_sector | output | 8 | Requested sector |
| store_index | output | IDX_W | Requested byte index |
| store_rdata | input | 8 | Store byte, valid the cycle after the request |

## Verification
The assertions assume that the store answers every request with a byte on the following cycle. They also assume that the host strobes are single-cycle pulses with a stable address, and never read and write in the same cycle. The bench's store model is a register loaded on each request. Every bus access in the bench is a task that raises one strobe for one clock edge only. Because of this, the polling counts seen by the bench map directly onto the fetch latency that the assertions check.

// File: rtl/fdc_mread.sv
module fdc_mread #(
  parameter int SECTOR_BYTES   = 256,
  parameter int TRACK_SECTORS  = 72,
  parameter int RESTORE_CYCLES = 4,
  parameter int DRIVES         = 4,
  localparam int IDX_W = $clog2(SECTOR_BYTES),
  localparam int DRV_W = (DRIVES > 1) ? $clog2(DRIVES) : 1,
  localparam int RC_W  = $clog2(RESTORE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             store_req,
  output logic [DRV_W-1:0] store_drive,
  output logic [7:0]       store_track,
  output logic [7:0]       store_sector,
  output logic [IDX_W-1:0] store_index,
  input  logic [7:0]       store_rdata
);

  localparam logic [2:0] A_CMD = 3'd0, A_TRK = 3'd1, A_SEC = 3'd2, A_DAT = 3'd3, A_DRV = 3'd4;
  localparam logic [7:0] CMD_HOME = 8'h0B, CMD_RDALL = 8'h9C;

  typedef enum logic [2:0] {S_IDLE, S_HOME, S_FETCH, S_CAPT, S_HOLD} state_t;

  state_t           state_q;
  logic [7:0]       track_q, sector_q, data_q;
  logic [DRV_W-1:0] drive_q;
  logic [IDX_W-1:0] idx_q;
  logic [RC_W-1:0]  rc_q;

  logic busy, drq, take, last_byte, last_sector;

  assign busy        = state_q != S_IDLE;
  assign drq         = state_q == S_HOLD;
  assign take        = bus_rd && bus_addr == A_DAT && drq;
  assign last_byte   = idx_q == IDX_W'(SECTOR_BYTES - 1);
  assign last_sector = sector_q >= 8'(TRACK_SECTORS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      track_q  <= '0;
      sector_q <= '0;
      data_q   <= '0;
      drive_q  <= '0;
      idx_q    <= '0;
      rc_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (bus_wr) begin
          case (bus_addr)
            A_CMD: begin
              if (bus_wdata == CMD_HOME) begin
                state_q <= S_HOME;
                rc_q    <= RC_W'(RESTORE_CYCLES - 1);
                track_q <= '0;
              end else if (bus_wdata == CMD_RDALL) begin
                state_q <= S_FETCH;
                idx_q   <= '0;
                if (sector_q == 8'd0) sector_q <= 8'd1;
              end
            end
            A_TRK: track_q  <= bus_wdata;
            A_SEC: sector_q <= bus_wdata;
            A_DRV: if (bus_wdata < 8'(DRIVES)) drive_q <= bus_wdata[DRV_W-1:0];
            default: ;
          endcase
        end
        S_HOME: begin
          if (rc_q == '0) state_q <= S_IDLE;
          else            rc_q    <= rc_q - 1'b1;
        end
        S_FETCH: state_q <= S_CAPT;
        S_CAPT: begin
          data_q  <= store_rdata;
          state_q <= S_HOLD;
        end
        S_HOLD: if (take) begin
          if (last_byte && last_sector) begin
            state_q <= S_IDLE;
          end else if (last_byte) begin
            sector_q <= sector_q + 8'd1;
            idx_q    <= '0;
            state_q  <= S_FETCH;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign store_req    = state_q == S_FETCH;
  assign store_drive  = drive_q;
  assign store_track  = track_q;
  assign store_sector = sector_q;
  assign store_index  = idx_q;

  always_comb begin
    case (bus_addr)
      A_CMD:   bus_rdata = {6'b0, drq, busy};
      A_TRK:   bus_rdata = track_q;
      A_SEC:   bus_rdata = sector_q;
      A_DAT:   bus_rdata = data_q;
      A_DRV:   bus_rdata = 8'(drive_q);
      default: bus_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/fdc_mread_chk.sv
module fdc_mread_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       drq,
  input logic       store_req,
  input logic       bus_rd,
  input logic [2:0] bus_addr,
  input logic [7:0] track_q
);

  assert_ready_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> busy);

  assert_req_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> busy);

  assert_req_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);

  assert_take_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd3 && drq) |=> !drq);

  assert_req_to_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> (!drq && busy));

  assert_ready_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !drq && !store_req && $past(store_req)) |=> drq);

  assert_track_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(track_q));

endmodule

bind fdc_mread fdc_mread_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .drq(drq), .store_req(store_req),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .track_q(track_q)
);

// File: tb/tb_fdc_mread.sv
module tb_fdc_mread;
  localparam int NSEC = 72;
  localparam int NBYTE = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       store_req;
  logic [1:0] store_drive;
  logic [7:0] store_track, store_sector;
  logic [7:0] store_index;
  logic [7:0] store_rdata = '0;

  int checks = 0, errors = 0, req_cnt = 0;

  always #2 clk = ~clk;

  fdc_mread dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .store_req(store_req),
    .store_drive(store_drive), .store_track(store_track), .store_sector(store_sector),
    .store_index(store_index), .store_rdata(store_rdata)
  );

  function automatic logic [7:0] pat(int d, int t, int s, int i);
    return 8'((s * 29 + i * 3 + d * 101 + t * 7) ^ (i >> 3));
  endfunction

  always @(posedge clk) begin
    if (store_req) begin
      store_rdata <= pat(int'(store_drive), int'(store_track), int'(store_sector), int'(store_index));
      req_cnt <= req_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_read(3'd0, v); check(v == 8'h00, "R1 status", v, 0);
    bus_read(3'd1, v); check(v == 8'h00, "R1 track", v, 0);
    bus_read(3'd2, v); check(v == 8'h00, "R1 sector", v, 0);
    bus_read(3'd4, v); check(v == 8'h00, "R1 drive", v, 0);
    check(req_cnt == 0, "R1 no store request", req_cnt, 0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    bus_write(3'd1, 8'h23); bus_read(3'd1, v); check(v == 8'h23, "R9 track", v, 8'h23);
    bus_write(3'd2, 8'h11); bus_read(3'd2, v); check(v == 8'h11, "R9 sector", v, 8'h11);
    bus_write(3'd4, 8'h02); bus_read(3'd4, v); check(v == 8'h02, "R9 drive", v, 2);
    bus_write(3'd4, 8'h07); bus_read(3'd4, v); check(v == 8'h02, "R12 bad drive ignored", v, 2);
    bus_write(3'd4, 8'h00);
  endtask

  task automatic t_unknown;
    logic [7:0] v;
    int r0 = req_cnt;
    bus_write(3'd0, 8'h55); bus_read(3'd0, v); check(v == 8'h00, "R10 cmd 55", v, 0);
    bus_write(3'd0, 8'h00); bus_read(3'd0, v); check(v == 8'h00, "R10 cmd 00", v, 0);
    bus_read(3'd1, v); check(v == 8'h23, "R10 track kept", v, 8'h23);
    check(req_cnt == r0, "R10 no request", req_cnt, r0);
  endtask

  task automatic t_restore;
    logic [7:0] v;
    int nb = 0;
    bit badfmt = 0;
    bus_write(3'd0, 8'h0B);
    for (int k = 0; k < 20; k++) begin
      bus_read(3'd0, v);
      if (v == 8'h00) break;
      if (v != 8'h01) badfmt = 1;
      nb++;
    end
    check(nb == 4, "R3 busy cycles", nb, 4);
    check(!badfmt, "R2 status while homing", badfmt, 0);
    bus_read(3'd1, v); check(v == 8'h00, "R3 track zero", v, 0);
  endtask

  task automatic t_ignore;
    logic [7:0] v;
    int r0;
    bus_write(3'd2, 8'h05);
    r0 = req_cnt;
    bus_write(3'd0, 8'h0B);
    bus_write(3'd2, 8'h09);
    bus_write(3'd0, 8'h9C);
    bus_write(3'd1, 8'h07);
    bus_write(3'd4, 8'h03);
    bus_read(3'd0, v); check(v == 8'h00, "R8 idle after", v, 0);
    bus_read(3'd2, v); check(v == 8'h05, "R8 sector kept", v, 5);
    bus_read(3'd1, v); check(v == 8'h00, "R8 track kept", v, 0);
    bus_read(3'd4, v); check(v == 8'h00, "R8 drive kept", v, 0);
    check(req_cnt == r0, "R8 cmd ignored", req_cnt, r0);
  endtask

  task automatic t_read(input int drv, input int start, input int first, input bit poke);
    logic [7:0] v;
    int r0, polls, bad, badpoll, e_act, e_exp;
    bus_write(3'd4, 8'(drv));
    bus_write(3'd2, 8'(start));
    r0 = req_cnt;
    bus_write(3'd0, 8'h9C);
    for (int s = first; s <= NSEC; s++) begin
      bad = 0; badpoll = 0; e_act = 0; e_exp = 0;
      for (int i = 0; i < NBYTE; i++) begin
        polls = 0;
        for (int k = 0; k < 10; k++) begin
          bus_read(3'd0, v);
          polls++;
          if (v[1]) break;
        end
        if (polls != 3 && badpoll == 0) badpoll = polls;
        if (i == 0) begin
          bus_read(3'd2, v);
          check(v == 8'(s), "R4 sector register", v, s);
        end
        if (poke && s == first && i == 5) bus_write(3'd1, 8'h09);
        bus_read(3'd3, v);
        if (v != pat(drv, 0, s, i) && bad == 0) begin
          bad = 1; e_act = v; e_exp = pat(drv, 0, s, i);
        end
      end
      check(bad == 0, (s == first && first == 1 && start == 0) ? "R5 R4 data" : "R4 data", e_act, e_exp);
      check(badpoll == 0, "R6 ready after three polls", badpoll, 3);
    end
    bus_read(3'd0, v); check(v == 8'h00, "R7 done status", v, 0);
    bus_read(3'd2, v); check(v == 8'(NSEC), "R7 last sector", v, NSEC);
    bus_read(3'd1, v); check(v == 8'h00, "R8 track during read", v, 0);
    check(req_cnt - r0 == (NSEC - first + 1) * NBYTE, "R11 request count",
          req_cnt - r0, (NSEC - first + 1) * NBYTE);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regs();
    t_unknown();
    t_restore();
    t_ignore();
    t_read(1, 70, 70, 1'b1);
    bus_write(3'd2, 8'h00);
    t_read(0, 0, 1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule